// File: doc/BRIEF.md
# Multiplexed ISDN Time-Slot Serial Port

This block attaches a line-side device to a shared time-division serial bus of the kind used between ISDN components. The bus runs from a data clock at twice the bit rate and an 8 kHz frame-sync pulse. Each 125 µs frame carries one, four or eight 32-bit channels placed back to back. A 3-bit slot number picks the one channel that belongs to this port.

Inside its channel the port shifts out a transmit word and shifts in a receive word. Both words are built from seven fields: two 8-bit bearer fields, an 8-bit maintenance field, a 2-bit signalling field, a 4-bit command/indication field and two single handshake bits. The receive fields are presented as parallel registers, with a one-cycle strobe when a fresh word is complete. Outside its channel the port enables no driver, keeps its data line high, and ignores the serial input.

Top module: `gci_port`

## Requirements
- R1: While `rst_n` is low, `ser_oe` is 0, `ser_out` is 1, `rx_valid` is 0 and every receive field register is 0.
- R2: A clock edge that samples `fsync_i` high makes the following cycle bit 0 of channel 0. Each bit occupies two clock cycles, so channel n covers cycles 64n to 64n+63 counted from that point.
- R3: `nch_sel_i` sets the channel count: 0 gives 1, 1 gives 4, and 2 or 3 give 8. When `slot_i` is below that count, `ser_oe` is 1 during exactly the 64 cycles of channel `slot_i`.
- R4: When `slot_i` is not below the configured count, `ser_oe` stays 0 for the whole frame, `rx_valid` never pulses and the receive registers keep their values.
- R5: The transmit word is {B1[7:0], B2[7:0], MON[7:0], D[1:0], CI[3:0], A, E}, bit 31 first and each bit held for both cycles of its cell. The word is taken from the transmit inputs at the start of the channel, and later changes to the inputs have no effect until the next frame.
- R6: Whenever `ser_oe` is 0, `ser_out` is 1.
- R7: Each receive bit is taken from `ser_in` in the second cycle of its cell. The value in the first cycle, and all input outside the selected channel, has no effect.
- R8: Receive bits are unpacked with the same layout as R5. The receive registers change only together with `rx_valid`.
- R9: `rx_valid` is high for exactly one cycle, the cycle after the last cell of the selected channel.
- R10: A frame-sync pulse in the middle of the selected channel restarts the count at channel 0. The partly received word is discarded, with no `rx_valid`, and the next complete channel is received normally.
- R11: After the last configured channel the port stays idle, with `ser_oe` at 0, until the next frame-sync pulse, however late that pulse comes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync pulse, one clock wide |
| nch_sel_i | input | 2 | Channels-per-frame selection |
| slot_i | input | 3 | Channel owned by this port |
| tx_b1 | input | 8 | First bearer field to send |
| tx_b2 | input | 8 | Second bearer field to send |
| tx_mon | input | 8 | Maintenance field to send |
| tx_d | input | 2 | Signalling field to send |
| tx_ci | input | 4 | Command/indication field to send |
| tx_a | input | 1 | First handshake bit to send |
| tx_e | input | 1 | Second handshake bit to send |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data, 1 when not driving |
| ser_oe | output | 1 | Driver enable, high only in own channel |
| rx_b1 | output | 8 | Received first bearer field |
| rx_b2 | output | 8 | Received second bearer field |
| rx_mon | output | 8 | Received maintenance field |
| rx_d | output | 2 | Received signalling field |
| rx_ci | output | 4 | Received command/indication field |
| rx_a | output | 1 | Received first handshake bit |
| rx_e | output | 1 | Received second handshake bit |
| rx_valid | output | 1 | One-cycle strobe for a new receive word |

## Verification
The hardest case to reach is a frame-sync pulse that lands in the middle of the port's own channel. It happens only if the stimulus cuts a frame short at a chosen cycle offset. The bench therefore ends one frame 30 cycles into channel 2 and starts a fresh one at once. It checks that no strobe appears and that the following full channel delivers only the new word. To show that only the second cycle of each cell counts, the bench drives the inverted bit in the first cycle and random data outside the slot. It also changes the transmit inputs right after the channel begins.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int CH_BITS = 32;
  localparam int CELL_CYC = 2;
  localparam int MAX_CH = 8;

  typedef struct packed {
    logic [7:0] b1;
    logic [7:0] b2;
    logic [7:0] mon;
    logic [1:0] d;
    logic [3:0] ci;
    logic       a;
    logic       e;
  } slot_word_t;
endpackage

// File: rtl/gci_slot_timer.sv
module gci_slot_timer #(
  parameter int MAX_CH  = gci_pkg::MAX_CH,
  parameter int CH_BITS = gci_pkg::CH_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fsync_i,
  input  logic [1:0]                 nch_sel_i,
  input  logic [$clog2(MAX_CH)-1:0]  slot_i,
  output logic                       active_o,
  output logic                       phase_o,
  output logic                       bit_last_o,
  output logic                       cell_end_o,
  output logic                       load_o
);
  localparam int PH_W  = 1;
  localparam int BIT_W = $clog2(CH_BITS);
  localparam int CH_W  = $clog2(MAX_CH);
  localparam int CNT_W = PH_W + BIT_W + CH_W;
  localparam int POS_W = PH_W + BIT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;
  logic [CH_W:0]    nch;
  logic [CH_W:0]    last_ch;
  logic             slot_ok;
  logic             at_end;

  always_comb begin
    case (nch_sel_i)
      2'd0:    nch = (CH_W+1)'(1);
      2'd1:    nch = (CH_W+1)'(MAX_CH / 2);
      default: nch = (CH_W+1)'(MAX_CH);
    endcase
  end

  assign last_ch = nch - (CH_W+1)'(1);
  assign slot_ok = ({1'b0, slot_i} < nch);
  assign at_end  = (cnt_q[CNT_W-1 -: CH_W] == last_ch[CH_W-1:0]) &&
                   (&cnt_q[POS_W-1:0]);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (fsync_i) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (at_end) run_d = 1'b0;
      else        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign cnt_en = fsync_i | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign active_o   = run_q && slot_ok && (cnt_q[CNT_W-1 -: CH_W] == slot_i);
  assign phase_o    = cnt_q[0];
  assign bit_last_o = &cnt_q[PH_W +: BIT_W];
  assign cell_end_o = active_o && phase_o && !fsync_i;
  assign load_o     = run_d && slot_ok && (cnt_d[CNT_W-1 -: CH_W] == slot_i) &&
                      (cnt_d[POS_W-1:0] == '0);
endmodule

// File: rtl/gci_tx_shift.sv
module gci_tx_shift #(
  parameter int W = gci_pkg::CH_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  input  logic         active_i,
  output logic         ser_out_o,
  output logic         ser_oe_o
);
  logic [W-1:0] sh_q, sh_d;
  logic         sh_en;

  always_comb begin
    sh_d = sh_q;
    if (load_i)       sh_d = word_i;
    else if (shift_i) sh_d = {sh_q[W-2:0], 1'b1};
  end

  assign sh_en = load_i | shift_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '1;
    else if (sh_en) sh_q <= sh_d;
  end

  assign ser_out_o = active_i ? sh_q[W-1] : 1'b1;
  assign ser_oe_o  = active_i;
endmodule

// File: rtl/gci_rx_shift.sv
module gci_rx_shift #(
  parameter int W = gci_pkg::CH_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in_i,
  input  logic         cell_end_i,
  input  logic         bit_last_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] word_q;
  logic         valid_q, valid_d;
  logic         done;

  assign sh_d    = {sh_q[W-2:0], ser_in_i};
  assign done    = cell_end_i & bit_last_i;
  assign valid_d = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sh_q <= '0;
    else if (cell_end_i) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (done) word_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/gci_port.sv
module gci_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync_i,
  input  logic [1:0] nch_sel_i,
  input  logic [2:0] slot_i,
  input  logic [7:0] tx_b1,
  input  logic [7:0] tx_b2,
  input  logic [7:0] tx_mon,
  input  logic [1:0] tx_d,
  input  logic [3:0] tx_ci,
  input  logic       tx_a,
  input  logic       tx_e,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       ser_oe,
  output logic [7:0] rx_b1,
  output logic [7:0] rx_b2,
  output logic [7:0] rx_mon,
  output logic [1:0] rx_d,
  output logic [3:0] rx_ci,
  output logic       rx_a,
  output logic       rx_e,
  output logic       rx_valid
);
  import gci_pkg::*;

  slot_word_t tx_word, rx_word;
  logic       active_w, phase_w, bit_last_w, cell_end_w, load_w;

  assign tx_word = '{b1: tx_b1, b2: tx_b2, mon: tx_mon, d: tx_d,
                     ci: tx_ci, a: tx_a, e: tx_e};

  gci_slot_timer #(.MAX_CH(MAX_CH), .CH_BITS(CH_BITS)) u_tim (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync_i    (fsync_i),
    .nch_sel_i  (nch_sel_i),
    .slot_i     (slot_i),
    .active_o   (active_w),
    .phase_o    (phase_w),
    .bit_last_o (bit_last_w),
    .cell_end_o (cell_end_w),
    .load_o     (load_w)
  );

  gci_tx_shift #(.W(CH_BITS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_w),
    .word_i    (tx_word),
    .shift_i   (cell_end_w),
    .active_i  (active_w),
    .ser_out_o (ser_out),
    .ser_oe_o  (ser_oe)
  );

  gci_rx_shift #(.W(CH_BITS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in_i   (ser_in),
    .cell_end_i (cell_end_w),
    .bit_last_i (bit_last_w),
    .word_o     (rx_word),
    .valid_o    (rx_valid)
  );

  assign rx_b1  = rx_word.b1;
  assign rx_b2  = rx_word.b2;
  assign rx_mon = rx_word.mon;
  assign rx_d   = rx_word.d;
  assign rx_ci  = rx_word.ci;
  assign rx_a   = rx_word.a;
  assign rx_e   = rx_word.e;
endmodule

// File: rtl/gci_port_chk.sv
module gci_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fsync_i,
  input logic [1:0] nch_sel_i,
  input logic [2:0] slot_i,
  input logic       ser_out,
  input logic       ser_oe,
  input logic       rx_valid,
  input logic       phase
);
  logic [3:0] lim;
  always_comb begin
    case (nch_sel_i)
      2'd0:    lim = 4'd1;
      2'd1:    lim = 4'd4;
      default: lim = 4'd8;
    endcase
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> ser_out); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
  AST_VALID_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(ser_oe)); // R9
  AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, slot_i} >= lim) |-> (!ser_oe && !rx_valid)); // R4
  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_i |=> (ser_oe == ($past(slot_i) == 3'd0))); // R2
  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && phase) |-> $stable(ser_out)); // R5
endmodule

bind gci_port gci_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fsync_i   (fsync_i),
  .nch_sel_i (nch_sel_i),
  .slot_i    (slot_i),
  .ser_out   (ser_out),
  .ser_oe    (ser_oe),
  .rx_valid  (rx_valid),
  .phase     (phase_w)
);

// File: tb/tb_gci_port.sv
module tb_gci_port;
  localparam int CLK_P = 10;

  logic       clk, rst_n, fsync_i, ser_in;
  logic [1:0] nch_sel_i;
  logic [2:0] slot_i;
  logic [7:0] tx_b1, tx_b2, tx_mon;
  logic [1:0] tx_d;
  logic [3:0] tx_ci;
  logic       tx_a, tx_e;
  logic       ser_out, ser_oe, rx_valid;
  logic [7:0] rx_b1, rx_b2, rx_mon;
  logic [1:0] rx_d;
  logic [3:0] rx_ci;
  logic       rx_a, rx_e;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] held_rx = '0;

  gci_port dut (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {nch_sel, slot, tx word, rx word}
  localparam logic [68:0] VEC [8] = '{
    {2'd0, 3'd0, 32'hA5C3_0F96, 32'h3C5A_F00D},
    {2'd1, 3'd0, 32'h1234_5678, 32'hFEDC_BA98},
    {2'd1, 3'd3, 32'hDEAD_BEEF, 32'h0F0F_55AA},
    {2'd1, 3'd5, 32'h8001_8001, 32'h7777_1111},
    {2'd2, 3'd7, 32'hC0FF_EE11, 32'h8000_0001},
    {2'd3, 3'd4, 32'h5A5A_A5A5, 32'h1357_9BDF},
    {2'd0, 3'd1, 32'hFFFF_0000, 32'h2468_ACE0},
    {2'd2, 3'd2, 32'h0000_FFFF, 32'hB00B_1E55}
  };

  function automatic int nchan(input logic [1:0] ns);
    return (ns == 2'd0) ? 1 : (ns == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [31:0] rx_word();
    return {rx_b1, rx_b2, rx_mon, rx_d, rx_ci, rx_a, rx_e};
  endfunction

  task automatic set_tx(input logic [31:0] w);
    {tx_b1, tx_b2, tx_mon, tx_d, tx_ci, tx_a, tx_e} = w;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one frame of len observed cycles starting with a sync pulse.
  task automatic run_frame(input logic [1:0] ns, input logic [2:0] sl,
                           input logic [31:0] tw, input logic [31:0] rw,
                           input int len);
    int n = nchan(ns);
    int base = int'(sl) * 64;
    bit ok = (int'(sl) < n);
    bit exp_valid = ok && (len > base + 64);
    int bad_oe = 0, bad_out = 0, n_valid = 0, bad_field = 0;
    nch_sel_i = ns;
    slot_i = sl;
    set_tx(tw);
    fsync_i = 1'b1;
    ser_in = 1'($urandom);
    @(negedge clk);
    fsync_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      bit act = ok && (k >= base) && (k < base + 64);
      logic bv;
      bv = rw[31 - ((k - base) / 2) % 32];
      if (act) ser_in = (k % 2 == 1) ? bv : ~bv;   // R7 only second cycle counts
      else     ser_in = 1'($urandom);
      if (act && k == base + 1) set_tx(~tw);       // R5 late change ignored
      if (ser_oe !== act) bad_oe++;
      if (act && ser_out !== tw[31 - (k - base) / 2]) bad_out++;
      if (!act && ser_out !== 1'b1) bad_out++;
      if (rx_valid === 1'b1) begin
        n_valid++;
        if (k != base + 64 || rx_word() !== rw) bad_field++;
      end
      @(negedge clk);
    end
    ser_in = 1'($urandom);
    chk(bad_oe == 0, "R3/R4/R11 enable window", 32'(bad_oe), 32'd0);
    chk(bad_out == 0, "R5/R6 serial output", 32'(bad_out), 32'd0);
    chk(n_valid == (exp_valid ? 1 : 0), "R9/R10 valid pulse count",
        32'(n_valid), exp_valid ? 32'd1 : 32'd0);
    chk(bad_field == 0, "R7/R8 receive fields at strobe", 32'(bad_field), 32'd0);
    if (exp_valid) held_rx = rw;
    chk(rx_word() === held_rx, "R8 receive registers hold", rx_word(), held_rx);
  endtask

  initial begin
    rst_n = 1'b0; fsync_i = 1'b0; ser_in = 1'b0;
    nch_sel_i = 2'd0; slot_i = 3'd0; set_tx('0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser_oe === 1'b0 && ser_out === 1'b1 && rx_valid === 1'b0,
        "R1 reset outputs", {29'd0, ser_oe, ser_out, rx_valid}, 32'h2);
    chk(rx_word() === 32'd0, "R1 reset fields", rx_word(), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11 (len beyond frame covers late sync)
    for (int i = 0; i < 8; i++) begin
      logic [68:0] v = VEC[i];
      run_frame(v[68:67], v[66:64], v[63:32], v[31:0], nchan(v[68:67]) * 64 + 6);
    end

    // R10 early sync in the middle of own channel, then a clean frame
    run_frame(2'd1, 3'd2, 32'h6161_6161, 32'hAAAA_5555, 2 * 64 + 30);
    run_frame(2'd1, 3'd2, 32'h9E37_79B9, 32'h0BAD_F00D, 4 * 64 + 2);

    // R2 back-to-back frames with slot 0 and a frame sync right after end
    run_frame(2'd0, 3'd0, 32'hCAFE_D00D, 32'h1111_EEEE, 64 + 1);
    run_frame(2'd0, 3'd0, 32'h0123_4567, 32'h89AB_CDEF, 64 + 1);

    // R1 reset in mid channel clears everything
    run_frame(2'd1, 3'd0, 32'hFFFF_FFFF, 32'h4242_4242, 20);
    rst_n = 1'b0;
    #1;
    chk(ser_oe === 1'b0 && ser_out === 1'b1 && rx_valid === 1'b0 &&
        rx_word() === 32'd0, "R1 mid-frame reset", rx_word(), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule